// File: doc/BRIEF.md
# Multi-Thread Variable-Latency Stage Scheduler

This block is one pipeline stage in a datapath that several hardware threads share. It sits around a single variable-latency operator. Work arrives from upstream tagged with a thread number. The stage passes the work straight to the operator and records, in a context slot owned by that thread, that the thread is waiting for its result. The operator may answer in any order, and each answer carries the thread number it belongs to. The answer is written into that thread's slot.

Every slot that holds a finished result is a candidate for the downstream port. A rotating-priority arbiter picks among the candidates, so a thread whose result is ready overtakes any thread still waiting on the operator. The operator and the output port are shared by all threads; only the small per-thread slots are replicated.

A thread may have at most one item inside the stage. For that reason each thread's results leave in the order the thread issued them, while results from different threads may leave in any order.

Top module: `mt_stage_sched`

## Requirements
- R1: After synchronous active-high reset, out_valid is 0, every thread's slot is free, so in_ready equals op_req_ready for any in_tid, and the arbiter starts its search at thread 0.
- R2: in_ready is 0 whenever the slot of the thread named by in_tid is occupied (waiting for the operator or holding an undelivered result).
- R3: in_ready is 0 whenever op_req_ready is 0. An accepted input appears on op_req_valid/op_req_tid/op_req_data in the same cycle, unchanged.
- R4: A response with op_rsp_tid = t, sent while thread t is waiting, is stored in slot t. It is later delivered with out_tid = t and out_data equal to the response data.
- R5: out_valid is 1 in a cycle exactly when at least one slot holds a completed result that has not been delivered.
- R6: When no output is being held, out_tid is the first thread holding a result, searching upward (with wraparound) from the thread after the last one delivered.
- R7: While out_valid is 1 and out_ready is 0, out_tid and out_data stay unchanged in the next cycle.
- R8: A response naming a thread that is not waiting has no effect: no output appears and no stored result changes.
- R9: A thread whose result is complete is delivered even while another thread, accepted earlier, is still waiting on the operator.
- R10: Every accepted item is delivered exactly once, and each thread's results leave in that thread's issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream work present |
| in_ready | output | 1 | Stage accepts the upstream work |
| in_tid | input | TID_W | Thread of the upstream work |
| in_data | input | DATA_W | Operand from upstream |
| op_req_valid | output | 1 | Request to the operator |
| op_req_ready | input | 1 | Operator can take a request |
| op_req_tid | output | TID_W | Thread of the request |
| op_req_data | output | DATA_W | Operand sent to the operator |
| op_rsp_valid | input | 1 | Operator result present |
| op_rsp_tid | input | TID_W | Thread the result belongs to |
| op_rsp_data | input | DATA_W | Result value |
| out_valid | output | 1 | A completed result is offered downstream |
| out_ready | input | 1 | Downstream takes the result |
| out_tid | output | TID_W | Thread of the offered result |
| out_data | output | DATA_W | Offered result value |

## Verification
A directed pattern issues two threads and completes only the younger one. This separates a stage that lets finished threads overtake from one that drains in issue order. Other directed steps send an answer to an idle thread, which exposes a design that writes stray answers into its slots, and hold off the operator's ready, which exposes a design that accepts without a request slot. Random traffic then mixes thread numbers, operator latencies from 0 to 15 cycles, and stalls on both handshakes. A bench model of the slots and of the rotating pointer predicts each offered thread and value. This shows up wrong priority, outputs that change while stalled, lost results and duplicated results.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int MTS_THREADS = 4;
    localparam int MTS_DATA_W  = 16;

    typedef enum logic [1:0] {
        CTX_FREE = 2'd0,
        CTX_WAIT = 2'd1,
        CTX_DONE = 2'd2
    } ctx_state_e;

    function automatic logic slot_busy(ctx_state_e s);
        return s != CTX_FREE;
    endfunction

endpackage

// File: rtl/mts_ctx_slot.sv
module mts_ctx_slot
    import mts_pkg::*;
#(
    parameter int DATA_W = MTS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              rsp_wr,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rel,
    output ctx_state_e        state,
    output logic [DATA_W-1:0] result
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CTX_FREE;
            result <= '0;
        end else begin
            case (state)
                CTX_FREE: if (acc) state <= CTX_WAIT;
                CTX_WAIT: if (rsp_wr) begin
                    state  <= CTX_DONE;
                    result <= rsp_data;
                end
                CTX_DONE: if (rel) state <= CTX_FREE;
                default:  state <= CTX_FREE;
            endcase
        end
    end

    // R2: a slot only takes new work when it is free
    p_accept_free_r2: assert property (@(posedge clk) disable iff (rst)
        acc |-> state == CTX_FREE);

    // R4: only a completed slot is released downstream
    p_release_done_r4: assert property (@(posedge clk) disable iff (rst)
        rel |-> state == CTX_DONE);

    // R8: an answer to a slot that is not waiting leaves its result untouched
    p_stray_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_wr && state != CTX_WAIT) |=> $stable(result));

endmodule

// File: rtl/mts_rr_arbiter.sv
module mts_rr_arbiter #(
    parameter int N     = 4,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    input  logic            take,
    output logic            any,
    output logic [ID_W-1:0] gidx
);

    logic [ID_W-1:0] ptr;
    logic [ID_W-1:0] pick;
    logic [ID_W-1:0] lock_idx;
    logic            locked;

    always_comb begin
        logic found;
        logic [ID_W-1:0] idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            idx = ID_W'((int'(ptr) + k) % N);
            if (!found && req[idx]) begin
                pick  = idx;
                found = 1'b1;
            end
        end
    end

    assign any  = |req;
    assign gidx = locked ? lock_idx : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            locked   <= 1'b0;
            lock_idx <= '0;
        end else if (any && take) begin
            ptr    <= ID_W'((int'(gidx) + 1) % N);
            locked <= 1'b0;
        end else if (any) begin
            locked   <= 1'b1;
            lock_idx <= gidx;
        end
    end

    // R6: the granted thread always has a completed result
    p_grant_valid_r6: assert property (@(posedge clk) disable iff (rst)
        any |-> req[gidx]);

endmodule

// File: rtl/mt_stage_sched.sv
module mt_stage_sched
    import mts_pkg::*;
#(
    parameter int N      = MTS_THREADS,
    parameter int DATA_W = MTS_DATA_W,
    localparam int TID_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TID_W-1:0]  in_tid,
    input  logic [DATA_W-1:0] in_data,
    output logic              op_req_valid,
    input  logic              op_req_ready,
    output logic [TID_W-1:0]  op_req_tid,
    output logic [DATA_W-1:0] op_req_data,
    input  logic              op_rsp_valid,
    input  logic [TID_W-1:0]  op_rsp_tid,
    input  logic [DATA_W-1:0] op_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TID_W-1:0]  out_tid,
    output logic [DATA_W-1:0] out_data
);

    ctx_state_e        st  [N];
    logic [DATA_W-1:0] res [N];
    logic [N-1:0]      done_vec;
    logic              busy_in;
    logic              accept;
    logic              deliver;
    logic [TID_W-1:0]  gidx;

    assign busy_in      = slot_busy(st[in_tid]);
    assign in_ready     = !busy_in && op_req_ready;
    assign op_req_valid = in_valid && !busy_in;
    assign op_req_tid   = in_tid;
    assign op_req_data  = in_data;
    assign accept       = in_valid && in_ready;
    assign deliver      = out_valid && out_ready;

    for (genvar i = 0; i < N; i++) begin : g_slot
        mts_ctx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .acc      (accept && in_tid == TID_W'(i)),
            .rsp_wr   (op_rsp_valid && op_rsp_tid == TID_W'(i)),
            .rsp_data (op_rsp_data),
            .rel      (deliver && gidx == TID_W'(i)),
            .state    (st[i]),
            .result   (res[i])
        );
        assign done_vec[i] = st[i] == CTX_DONE;
    end

    mts_rr_arbiter #(.N(N)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (done_vec),
        .take (out_ready),
        .any  (out_valid),
        .gidx (gidx)
    );

    assign out_tid  = gidx;
    assign out_data = res[gidx];

    // R1: nothing is offered right after reset
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R3: every accepted item is presented to the operator
    p_req_on_accept_r3: assert property (@(posedge clk) disable iff (rst)
        accept |-> (op_req_valid && op_req_ready));

    // R7: a stalled output keeps its thread and value
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tid) && $stable(out_data)));

endmodule

// File: tb/mt_stage_sched_test.sv
module mt_stage_sched_test;

    localparam int N      = 4;
    localparam int DATA_W = 16;
    localparam int TID_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TID_W-1:0]  in_tid = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              op_req_valid;
    logic              op_req_ready = 1'b1;
    logic [TID_W-1:0]  op_req_tid;
    logic [DATA_W-1:0] op_req_data;
    logic              op_rsp_valid = 1'b0;
    logic [TID_W-1:0]  op_rsp_tid = '0;
    logic [DATA_W-1:0] op_rsp_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [TID_W-1:0]  out_tid;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int failures = 0;

    // bench model: 0 free, 1 waiting, 2 done
    int m_state [N];
    int m_op    [N];
    int m_lat   [N];
    int issued  [N];
    int deliv   [N];
    int m_ptr;
    int m_hold;
    int m_hold_tid;

    mt_stage_sched #(.N(N), .DATA_W(DATA_W)) uut (.*);

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] opfun(int v);
        return DATA_W'(v * 5 + 7);
    endfunction

    function automatic int exp_pick();
        for (int k = 0; k < N; k++) begin
            if (m_state[(m_ptr + k) % N] == 2) return (m_ptr + k) % N;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < N; t++) begin
            m_state[t] = 0; m_op[t] = 0; m_lat[t] = 0; issued[t] = 0; deliv[t] = 0;
        end
        m_ptr = 0; m_hold = 0; m_hold_tid = 0;
    endtask

    // inputs are already set at the falling edge; check, update model, advance
    task automatic step();
        int any_done;
        int exp_t;
        int t_in;
        #1;
        any_done = 0;
        for (int t = 0; t < N; t++) if (m_state[t] == 2) any_done = 1;
        chk(out_valid == any_done[0], "R5 out_valid", int'(out_valid), any_done);
        exp_t = m_hold ? m_hold_tid : exp_pick();
        if (out_valid && exp_t >= 0) begin
            chk(int'(out_tid) == exp_t, "R6/R7 out_tid", int'(out_tid), exp_t);
            chk(out_data == opfun(m_op[exp_t]), "R4 out_data", int'(out_data), int'(opfun(m_op[exp_t])));
        end
        t_in = int'(in_tid);
        if (in_valid) begin
            chk(in_ready == (m_state[t_in] == 0 && op_req_ready), "R2/R3 in_ready",
                int'(in_ready), int'(m_state[t_in] == 0 && op_req_ready));
            if (m_state[t_in] == 0)
                chk(op_req_valid && op_req_tid == in_tid && op_req_data == in_data,
                    "R3 request passthrough", int'(op_req_data), int'(in_data));
        end
        // model update (takes effect at the coming edge)
        for (int t = 0; t < N; t++) if (m_state[t] == 1 && m_lat[t] > 0) m_lat[t]--;
        if (op_rsp_valid && m_state[int'(op_rsp_tid)] == 1) m_state[int'(op_rsp_tid)] = 2;
        if (out_valid && exp_t >= 0) begin
            if (out_ready) begin
                m_state[exp_t] = 0;
                deliv[exp_t]++;
                m_ptr = (exp_t + 1) % N;
                m_hold = 0;
            end else begin
                m_hold = 1;
                m_hold_tid = exp_t;
            end
        end
        if (in_valid && in_ready) begin
            m_state[t_in] = 1;
            m_op[t_in] = int'(in_data);
            m_lat[t_in] = int'($urandom % 16);
            issued[t_in]++;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; op_rsp_valid = 1'b0; out_ready = 1'b0; op_req_ready = 1'b1;
    endtask

    task automatic respond(input int t);
        op_rsp_valid = 1'b1;
        op_rsp_tid   = TID_W'(t);
        op_rsp_data  = opfun(m_op[t]);
    endtask

    task automatic rand_rsp();
        int s;
        op_rsp_valid = 1'b0;
        s = int'($urandom % N);
        for (int k = 0; k < N; k++) begin
            if (!op_rsp_valid && m_state[(s + k) % N] == 1 && m_lat[(s + k) % N] == 0)
                respond((s + k) % N);
        end
        if (!op_rsp_valid && ($urandom % 8 == 0) && m_state[s] == 0) begin
            op_rsp_valid = 1'b1;           // stray answer, R8
            op_rsp_tid   = TID_W'(s);
            op_rsp_data  = DATA_W'($urandom);
        end
    endtask

    initial begin
        int pending;
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset, any thread admitted
        in_valid = 1'b1; in_tid = 2'd3; in_data = 16'd100; op_req_ready = 1'b0;
        #1;
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(!in_ready, "R3 ready with op stalled", int'(in_ready), 0);
        op_req_ready = 1'b1;
        #1;
        chk(in_ready, "R1 slot free", int'(in_ready), 1);
        in_valid = 1'b0;
        @(negedge clk);

        // R8: stray answer to idle thread 2
        idle_inputs();
        op_rsp_valid = 1'b1; op_rsp_tid = 2'd2; op_rsp_data = 16'hBEEF;
        step();
        idle_inputs();
        #1;
        chk(!out_valid, "R8 stray ignored", int'(out_valid), 0);
        step();

        // R9: thread 0 then thread 1 issued, only thread 1 completes
        in_valid = 1'b1; in_tid = 2'd0; in_data = 16'd11; step();
        in_tid = 2'd1; in_data = 16'd22; step();
        idle_inputs(); respond(1); step();
        idle_inputs(); in_valid = 1'b1; in_tid = 2'd0; in_data = 16'd33;
        #1;
        chk(out_valid && out_tid == 2'd1 && m_state[0] == 1, "R9 overtake", int'(out_tid), 1);
        chk(!in_ready, "R2 busy thread blocked", int'(in_ready), 0);
        step();
        idle_inputs(); step();             // held output, R7
        idle_inputs(); out_ready = 1'b1; step();
        idle_inputs(); respond(0); step();
        idle_inputs(); out_ready = 1'b1; step();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            in_valid     = ($urandom % 3) != 0;
            in_tid       = TID_W'($urandom);
            in_data      = DATA_W'($urandom);
            op_req_ready = ($urandom % 4) != 0;
            out_ready    = ($urandom % 3) != 0;
            rand_rsp();
            step();
        end

        // drain
        for (int c = 0; c < 400; c++) begin
            in_valid = 1'b0; out_ready = 1'b1; op_req_ready = 1'b1;
            rand_rsp();
            step();
        end
        idle_inputs();
        pending = 0;
        for (int t = 0; t < N; t++) begin
            if (m_state[t] != 0) pending++;
            chk(issued[t] == deliv[t] && issued[t] > 0, "R10 delivered once", deliv[t], issued[t]);
        end
        chk(pending == 0, "R10 drained", pending, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule